// File: doc/BRIEF.md
# Retry Page Fault Filter

This block sits in an interrupt vector stream and decides, one vector at a time, whether a vector travels on or is discarded. Each vector is carried as four 32-bit words (here called word 0, word 3, word 4 and word 5, after their positions in the full vector). The filter looks only at the memory-fault vectors. A retry fault is forwarded only when it is the first one for its address-space id and page. Later copies are discarded until an external clear retires the key. A new retry fault is also discarded while the key table is full.

Vectors from other clients, and fault vectors with no address-space id, pass through unchanged. Non-retry faults pass only when an external credit grant, sampled with the vector, is high. Both edges of the block use valid/ready. A vector is taken on a clock edge where `in_valid` and `in_ready` are both high. The output holds `out_valid` and its data until a clock edge where `out_ready` is high. The single holding stage waits whenever the output register is occupied and not being drained. `in_ready` is low while that stage is full and cannot advance. Each discarded vector raises `drop_pulse` for one cycle so that a counter outside can tally it.

Top module: `pf_retry_filter`

## Requirements
- R1: After reset, `out_valid` and `drop_pulse` are low, `in_ready` is high and the key table is empty.
- R2: A vector whose client id (word0[7:0]) is neither 0x12 nor 0x1B is forwarded with all four words unchanged, however often it repeats.
- R3: A vector from client 0x12 or 0x1B whose address-space id (word3[15:0]) is zero is forwarded, even when it is a repeated retry fault.
- R4: A fault vector with a nonzero id and word5[7] = 0 (non-retry) is forwarded when `in_grant` was high at acceptance and discarded when it was low.
- R5: A retry fault (word5[7] = 1) whose key {word3[15:0], word5[3:0], word4[31:0]} (52 bits) is not in the table is stored and forwarded. Keys that differ only in word5[3:0] are distinct.
- R6: A retry fault whose key is already in the table is discarded.
- R7: A retry fault with a new key that arrives while all DEPTH (default 8) entries are in use is discarded and is not stored.
- R8: A `clr_valid` cycle with a stored key in `clr_key` frees that entry. A later retry fault with that key is stored and forwarded again.
- R9: When a clear and a decision fall in the same cycle, the clear is applied first. A retry fault whose key is being cleared is treated as new, and the freed slot is available to it.
- R10: A vector accepted at clock edge k gives `out_valid` or a one-cycle `drop_pulse` after edge k+1, never after edge k alone.
- R11: While `out_ready` is low, `out_valid` and the output words hold steady. `in_ready` falls once the holding stage is also full. Vectors leave in acceptance order with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Filter can take a vector |
| in_w0 | input | 32 | Word 0: client id in [7:0] |
| in_w3 | input | 32 | Word 3: address-space id in [15:0] |
| in_w4 | input | 32 | Word 4: low page-number bits |
| in_w5 | input | 32 | Word 5: retry flag in [7], high page bits in [3:0] |
| in_grant | input | 1 | Credit grant for non-retry faults, sampled with the vector |
| out_valid | output | 1 | Forwarded vector valid |
| out_ready | input | 1 | Downstream takes the forwarded vector |
| out_w0 | output | 32 | Forwarded word 0 |
| out_w3 | output | 32 | Forwarded word 3 |
| out_w4 | output | 32 | Forwarded word 4 |
| out_w5 | output | 32 | Forwarded word 5 |
| drop_pulse | output | 1 | One-cycle pulse per discarded vector |
| clr_valid | input | 1 | Retire a key this cycle |
| clr_key | input | 52 | Key to retire: {id, page high nibble, page low word} |

## Verification
The clear port and the decision on a held retry fault can act on the key table in the same cycle. The bench forces this by raising `clr_valid` in the cycle right after a vector is accepted, so the clear meets the vector's decision edge. In one case the vector carries the key being cleared into a full table, and it must be forwarded and then stored again. A following duplicate must be discarded. In the other case a different key is cleared, and the new vector must take the slot that clear frees.

// File: rtl/pf_filter_pkg.sv
package pf_filter_pkg;
  localparam int PASID_W = 16;
  localparam int PAGE_W  = 36;
  localparam int KEY_W   = PASID_W + PAGE_W;

  typedef logic [KEY_W-1:0] fault_key_t;

  typedef enum logic [1:0] {
    CLS_OTHER   = 2'd0,
    CLS_NOPASID = 2'd1,
    CLS_CREDIT  = 2'd2,
    CLS_RETRY   = 2'd3
  } vec_class_e;

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w3;
    logic [31:0] w4;
    logic [31:0] w5;
  } vec_t;
endpackage

// File: rtl/pf_classify.sv
module pf_classify
  import pf_filter_pkg::*;
#(
  parameter logic [7:0] CLIENT_A = 8'h12,
  parameter logic [7:0] CLIENT_B = 8'h1B
) (
  input  logic [7:0]         client,
  input  logic [PASID_W-1:0] pasid,
  input  logic               retry,
  input  logic [PAGE_W-1:0]  page,
  output vec_class_e         cls,
  output fault_key_t         key
);
  logic is_fault_client;

  assign is_fault_client = (client == CLIENT_A) || (client == CLIENT_B);
  assign key = {pasid, page};

  always_comb begin
    if (!is_fault_client)    cls = CLS_OTHER;
    else if (pasid == '0)    cls = CLS_NOPASID;
    else if (!retry)         cls = CLS_CREDIT;
    else                     cls = CLS_RETRY;
  end
endmodule

// File: rtl/pf_key_table.sv
module pf_key_table
  import pf_filter_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_en,
  input  fault_key_t clr_key,
  input  fault_key_t look_key,
  input  logic       ins_en,
  output logic       hit,
  output logic       full
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] clr_match;
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] ins_sel;
  fault_key_t       key_q [DEPTH];

  // Clear is resolved before lookup and slot choice.
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign clr_match[g] = clr_en && valid_q[g] && (key_q[g] == clr_key);
    assign live[g]      = valid_q[g] && !clr_match[g];
    assign hit_vec[g]   = live[g] && (key_q[g] == look_key);
  end

  assign hit  = |hit_vec;
  assign full = &live;

  always_comb begin
    logic found;
    found   = 1'b0;
    ins_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !live[i]) begin
        ins_sel[i] = ins_en;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= live | ins_sel;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_sel[i]) key_q[i] <= look_key;
    end
  end

  AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R6
  AST_INS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (!hit && !full)); // R7
  AST_INS_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> ($countones(valid_q) == $past($countones(live)) + 1)); // R5
  AST_TABLE_RESET: assert property (@(posedge clk)
    $past(!rst_n) |-> (valid_q == '0)); // R1
endmodule

// File: rtl/pf_retry_filter.sv
module pf_retry_filter
  import pf_filter_pkg::*;
#(
  parameter int         DEPTH    = 8,
  parameter logic [7:0] CLIENT_A = 8'h12,
  parameter logic [7:0] CLIENT_B = 8'h1B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_w0,
  input  logic [31:0] in_w3,
  input  logic [31:0] in_w4,
  input  logic [31:0] in_w5,
  input  logic        in_grant,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_w0,
  output logic [31:0] out_w3,
  output logic [31:0] out_w4,
  output logic [31:0] out_w5,
  output logic        drop_pulse,
  input  logic        clr_valid,
  input  logic [51:0] clr_key
);
  vec_t       s_vec;
  vec_t       o_vec;
  logic       s_valid;
  logic       s_grant;
  logic       out_free;
  logic       accept;
  logic       decide;
  logic       pass;
  logic       hit;
  logic       full;
  logic       ins_en;
  vec_class_e cls;
  fault_key_t key;

  assign out_free = !out_valid || out_ready;
  assign in_ready = !s_valid || out_free;
  assign accept   = in_valid && in_ready;
  assign decide   = s_valid && out_free;

  pf_classify #(.CLIENT_A(CLIENT_A), .CLIENT_B(CLIENT_B)) u_cls (
    .client (s_vec.w0[7:0]),
    .pasid  (s_vec.w3[PASID_W-1:0]),
    .retry  (s_vec.w5[7]),
    .page   ({s_vec.w5[3:0], s_vec.w4}),
    .cls    (cls),
    .key    (key)
  );

  pf_key_table #(.DEPTH(DEPTH)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (clr_valid),
    .clr_key  (clr_key),
    .look_key (key),
    .ins_en   (ins_en),
    .hit      (hit),
    .full     (full)
  );

  always_comb begin
    unique case (cls)
      CLS_OTHER, CLS_NOPASID: pass = 1'b1;
      CLS_CREDIT:             pass = s_grant;
      default:                pass = !hit && !full;
    endcase
  end

  assign ins_en = decide && (cls == CLS_RETRY) && !hit && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid    <= 1'b0;
      out_valid  <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      if (accept)      s_valid <= 1'b1;
      else if (decide) s_valid <= 1'b0;
      if (decide && pass)  out_valid <= 1'b1;
      else if (out_ready)  out_valid <= 1'b0;
      drop_pulse <= decide && !pass;
    end
    if (accept) begin
      s_vec   <= '{w0: in_w0, w3: in_w3, w4: in_w4, w5: in_w5};
      s_grant <= in_grant;
    end
    if (decide && pass) o_vec <= s_vec;
  end

  assign out_w0 = o_vec.w0;
  assign out_w3 = o_vec.w3;
  assign out_w4 = o_vec.w4;
  assign out_w5 = o_vec.w5;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(o_vec))); // R11
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && out_valid && !out_ready) |-> !in_ready); // R11
  AST_DROP_FROM_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(s_valid)); // R10
  AST_OTHER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cls == CLS_OTHER) |=> (out_valid && !drop_pulse)); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rst_n) |-> (!out_valid && !drop_pulse && in_ready)); // R1
endmodule

// File: tb/pf_retry_filter_test.sv
module pf_retry_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_w0 = '0, in_w3 = '0, in_w4 = '0, in_w5 = '0;
  logic        in_grant = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_w0, out_w3, out_w4, out_w5;
  logic        drop_pulse;
  logic        clr_valid = 1'b0;
  logic [51:0] clr_key = '0;

  int checks = 0;
  int fails = 0;
  int drops_seen = 0;
  int drops_exp = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  pf_retry_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_w0(in_w0), .in_w3(in_w3), .in_w4(in_w4), .in_w5(in_w5),
    .in_grant(in_grant), .out_valid(out_valid), .out_ready(out_ready),
    .out_w0(out_w0), .out_w3(out_w3), .out_w4(out_w4), .out_w5(out_w5),
    .drop_pulse(drop_pulse), .clr_valid(clr_valid), .clr_key(clr_key)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop and drop counting.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected output", {out_w0, out_w3, out_w4, out_w5}, '0);
      end else begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_w0, out_w3, out_w4, out_w5} == e, t, {out_w0, out_w3, out_w4, out_w5}, e);
      end
    end
    if (rst_n && drop_pulse) drops_seen++;
  end

  function automatic logic [127:0] mkvec(input logic [7:0] client, input logic [15:0] pasid,
                                         input bit retry, input logic [3:0] hi, input logic [31:0] lo);
    return {8'h3C, 8'h01, 8'h77, client, 16'h8000, pasid, lo, 24'h00C0FE, retry, 3'b010, hi};
  endfunction

  task automatic drive(input logic [127:0] v, input bit grant);
    @(negedge clk);
    in_valid = 1'b1;
    {in_w0, in_w3, in_w4, in_w5} = v;
    in_grant = grant;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] client, input logic [15:0] pasid, input bit retry,
                      input logic [3:0] hi, input logic [31:0] lo, input bit grant,
                      input bit pass, input string tag);
    logic [127:0] v;
    v = mkvec(client, pasid, retry, hi, lo);
    if (pass) begin exp_q.push_back(v); tag_q.push_back(tag); end
    else drops_exp++;
    drive(v, grant);
  endtask

  task automatic clear(input logic [15:0] pasid, input logic [3:0] hi, input logic [31:0] lo);
    @(negedge clk);
    clr_valid = 1'b1;
    clr_key = {pasid, hi, lo};
    @(posedge clk);
    #1 clr_valid = 1'b0;
  endtask

  // Clear lands on the decision edge of the vector just sent.
  task automatic send_clr(input logic [15:0] pasid, input logic [3:0] hi, input logic [31:0] lo,
                          input logic [51:0] ck, input bit pass, input string tag);
    send(8'h12, pasid, 1'b1, hi, lo, 1'b0, pass, tag);
    @(negedge clk);
    clr_valid = 1'b1;
    clr_key = ck;
    @(posedge clk);
    #1 clr_valid = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (4) @(negedge clk);
    check(drops_seen == drops_exp, req, drops_seen, drops_exp);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !drop_pulse, "R1 outputs idle in reset", {out_valid, drop_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid && !drop_pulse, "R1 ready after reset", {in_ready, out_valid, drop_pulse}, 3'b100);

    // R2: other clients pass, even repeated
    send(8'h33, 16'd4, 1'b1, 4'h0, 32'h10, 1'b0, 1'b1, "R2 other client");
    send(8'h33, 16'd4, 1'b1, 4'h0, 32'h10, 1'b0, 1'b1, "R2 other client repeat");
    // R3: zero id passes
    send(8'h12, 16'd0, 1'b1, 4'h0, 32'h20, 1'b0, 1'b1, "R3 zero id");
    send(8'h1B, 16'd0, 1'b1, 4'h0, 32'h20, 1'b0, 1'b1, "R3 zero id repeat");
    // R4: credit for non-retry
    send(8'h1B, 16'd7, 1'b0, 4'h0, 32'h30, 1'b1, 1'b1, "R4 grant high");
    send(8'h1B, 16'd7, 1'b0, 4'h0, 32'h30, 1'b0, 1'b0, "R4 grant low");
    settle("R4 drop count");

    // R5: fill table with distinct keys (hi nibble alone distinguishes k0/k1)
    send(8'h12, 16'd9, 1'b1, 4'h0, 32'h0, 1'b0, 1'b1, "R5 k0");
    send(8'h12, 16'd9, 1'b1, 4'h1, 32'h0, 1'b0, 1'b1, "R5 k1 hi nibble");
    for (int i = 2; i < 8; i++)
      send(8'h1B, 16'd9, 1'b1, 4'h0, i, 1'b0, 1'b1, "R5 fill");
    // R6: duplicate drops
    send(8'h12, 16'd9, 1'b1, 4'h1, 32'h0, 1'b0, 1'b0, "R6 dup");
    // R7: full drops new key
    send(8'h12, 16'd9, 1'b1, 4'h0, 32'h8, 1'b0, 1'b0, "R7 full");
    settle("R6 R7 drop count");

    // R8: clear frees slot
    clear(16'd9, 4'h0, 32'h3);
    send(8'h12, 16'd9, 1'b1, 4'h0, 32'h8, 1'b0, 1'b1, "R8 new after clear");
    send(8'h12, 16'd9, 1'b1, 4'h0, 32'h3, 1'b0, 1'b0, "R7 full after refill");
    settle("R8 drop count");

    // R9: clear of same key on decision edge
    send_clr(16'd9, 4'h0, 32'h8, {16'd9, 4'h0, 32'h8}, 1'b1, "R9 same key clear first");
    send(8'h12, 16'd9, 1'b1, 4'h0, 32'h8, 1'b0, 1'b0, "R9 reinserted dup");
    // R9: clear of other key frees slot for new key
    send_clr(16'd9, 4'h0, 32'h9, {16'd9, 4'h0, 32'h0}, 1'b1, "R9 freed slot used");
    settle("R9 drop count");

    // R10: timing of output and drop
    @(negedge clk);
    in_valid = 1'b1;
    {in_w0, in_w3, in_w4, in_w5} = mkvec(8'h44, 16'd1, 1'b0, 4'h0, 32'h55);
    exp_q.push_back(mkvec(8'h44, 16'd1, 1'b0, 4'h0, 32'h55)); tag_q.push_back("R10 data");
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R10 no output after accept edge", out_valid, 0);
    @(negedge clk);
    check(out_valid, "R10 output after second edge", out_valid, 1);
    @(negedge clk);
    in_valid = 1'b1;
    {in_w0, in_w3, in_w4, in_w5} = mkvec(8'h12, 16'd2, 1'b0, 4'h0, 32'h66);
    in_grant = 1'b0;
    drops_exp++;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    check(!drop_pulse, "R10 no drop after accept edge", drop_pulse, 0);
    @(negedge clk);
    check(drop_pulse, "R10 drop after second edge", drop_pulse, 1);
    @(negedge clk);
    check(!drop_pulse, "R10 drop lasts one cycle", drop_pulse, 0);
    settle("R10 drop count");

    // R11: back-pressure
    out_ready = 1'b0;
    send(8'h50, 16'd3, 1'b0, 4'h0, 32'hA1, 1'b0, 1'b1, "R11 first");
    send(8'h51, 16'd3, 1'b0, 4'h0, 32'hA2, 1'b0, 1'b1, "R11 second");
    repeat (2) @(negedge clk);
    check(out_valid && !in_ready, "R11 stall", {out_valid, in_ready}, 2'b10);
    check(out_w4 == 32'hA1, "R11 held data", out_w4, 32'hA1);
    repeat (3) @(negedge clk);
    check(out_valid && out_w4 == 32'hA1, "R11 still held", out_w4, 32'hA1);
    out_ready = 1'b1;
    settle("R11 drained in order");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule